// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block catches runaway software. A down-counter is clocked by a prescaler that runs on the bus clock. The prescaler's ratio depends on two things: which oscillator currently drives the bus clock, and a ratio-select field that software writes. Software must write the start/refresh strobe often enough to keep the counter from reaching its end. When the counter underflows, the block raises a one-cycle non-maskable interrupt request.

After reset the block is idle until the first start write. From then on it keeps running until the next reset. While the chip sits in a low-power or bus-hold state, the counter and the prescaler freeze and resume where they stopped. A refresh reloads only the counter. The prescaler keeps its phase, so a refresh shortens the next tick by whatever part of a prescaler period has already passed.

The block carries no data stream. Every pin is a plain control or status signal with no handshake, and a write strobe takes effect on the clock edge where it is high.

Top module: `wdt_prescaled`

## Requirements
- R1: After reset, count_o reads the full value 2^CNT_W-1 and nmi_req_o is low. Nothing counts until the first start write.
- R2: A start write reloads the counter to 2^CNT_W-1 on that edge, whatever the counter holds.
- R3: With src_sub_i low (main oscillator), the ratio-select field gives one counter tick every 16 bus clocks when it is 0, and every 128 bus clocks when it is 1.
- R4: With src_sub_i high (sub oscillator), one counter tick occurs every 2 bus clocks, whatever the ratio-select field holds.
- R5: On the tick after zero, the counter wraps to full and nmi_req_o is high for exactly one cycle, in the cycle where count_o first shows the wrapped value. One full period is 2^CNT_W ticks.
- R6: Only reset clears the prescaler. A start write leaves its phase unchanged.
- R7: While hold_i is high, the counter and the prescaler keep their values. When hold_i falls they resume, so the underflow moves later by exactly the number of held cycles.
- R8: If a start write falls in the same cycle as an underflow tick, the reload wins and no interrupt request is raised.
- R9: A change of ratio, from the select field or from the clock source, takes effect only when the prescaler next rolls over. The current prescaler period finishes at the old ratio.
- R10: Once set by a start write, the running state stays set until reset. Hold only pauses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| src_sub_i | input | 1 | 1: the sub oscillator drives the bus clock; 0: the main oscillator does |
| ctrl_we_i | input | 1 | Write strobe for the ratio-select field |
| ctrl_sel_i | input | 1 | Value written to the ratio-select field (0: 16, 1: 128, main oscillator only) |
| start_we_i | input | 1 | Start/refresh write strobe |
| hold_i | input | 1 | Freeze request for stop, wait or hold state |
| nmi_req_o | output | 1 | One-cycle non-maskable interrupt request on underflow |
| count_o | output | CNT_W | Current counter value |

## Verification
The bench builds the block with CNT_W set to 6 and leaves the ratio parameters at 2, 16 and 128. The slowest full period is therefore 8192 bus clocks instead of about four million. This puts many underflows at all three ratios within reach, along with refreshes at chosen prescaler phases, a refresh on the exact underflow edge and a ratio switch in the middle of a prescaler period. The counter width is the only thing scaled down, so the prescaler, the ratio selection and the freeze path are the same logic as at the default width.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    RATIO_SUB  = 2'd0,
    RATIO_FAST = 2'd1,
    RATIO_SLOW = 2'd2
  } wdt_ratio_e;

  // The sub oscillator forces the short ratio; otherwise the select field picks one.
  function automatic wdt_ratio_e ratio_pick(input logic on_sub, input logic slow_sel);
    if (on_sub) return RATIO_SUB;
    return slow_sel ? RATIO_SLOW : RATIO_FAST;
  endfunction

endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_sub_i,
  input  logic       ctrl_we_i,
  input  logic       ctrl_sel_i,
  input  logic       start_we_i,
  output wdt_ratio_e ratio_o,
  output logic       run_o
);

  logic sel_q;
  logic run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      if (ctrl_we_i) sel_q <= ctrl_sel_i;
      if (start_we_i) run_q <= 1'b1;
    end
  end

  always_comb ratio_o = ratio_pick(src_sub_i, sel_q);
  assign run_o = run_q;

  // R10
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> run_q);

  // R10
  run_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start_we_i) |=> !run_q);

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int DIV_SUB  = 2,
  parameter int DIV_FAST = 16,
  parameter int DIV_SLOW = 128,
  parameter int PRE_W    = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic       active_i,
  input  wdt_ratio_e ratio_i,
  output logic       tick_o
);

  localparam logic [PRE_W-1:0] TERM_SUB  = PRE_W'(DIV_SUB - 1);
  localparam logic [PRE_W-1:0] TERM_FAST = PRE_W'(DIV_FAST - 1);
  localparam logic [PRE_W-1:0] TERM_SLOW = PRE_W'(DIV_SLOW - 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] term_q;
  logic [PRE_W-1:0] term_now;

  always_comb begin
    unique case (ratio_i)
      RATIO_SUB:  term_now = TERM_SUB;
      RATIO_SLOW: term_now = TERM_SLOW;
      default:    term_now = TERM_FAST;
    endcase
  end

  assign tick_o = active_i && (pre_q == term_q);

  // While idle the terminal value follows the selection; once running it is
  // only reloaded at a rollover.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      term_q <= TERM_FAST;
    end else if (!run_i) begin
      term_q <= term_now;
    end else if (tick_o) begin
      pre_q  <= '0;
      term_q <= term_now;
    end else if (active_i) begin
      pre_q  <= pre_q + 1'b1;
    end
  end

  // R7
  pre_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> $stable(pre_q));

  // R9
  term_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !tick_o) |=> $stable(term_q));

  // R6
  pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (pre_q <= term_q));

endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             nmi_o
);

  localparam logic [CNT_W-1:0] FULL = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             nmi_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= FULL;
      nmi_q <= 1'b0;
    end else begin
      nmi_q <= tick_i && at_zero && !load_i;
      if (load_i)
        cnt_q <= FULL;
      else if (tick_i)
        cnt_q <= at_zero ? FULL : cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign nmi_o = nmi_q;

  // R2
  reload_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == FULL));

  // R5
  nmi_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_q |-> (cnt_q == FULL));

  // R7
  cnt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(cnt_q));

endmodule

// File: rtl/wdt_prescaled.sv
module wdt_prescaled
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 15,
  parameter int DIV_SUB  = 2,
  parameter int DIV_FAST = 16,
  parameter int DIV_SLOW = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_sub_i,
  input  logic             ctrl_we_i,
  input  logic             ctrl_sel_i,
  input  logic             start_we_i,
  input  logic             hold_i,
  output logic             nmi_req_o,
  output logic [CNT_W-1:0] count_o
);

  localparam int DIV_MAX_A = (DIV_SUB > DIV_FAST) ? DIV_SUB : DIV_FAST;
  localparam int DIV_MAX   = (DIV_MAX_A > DIV_SLOW) ? DIV_MAX_A : DIV_SLOW;
  localparam int PRE_W     = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
  localparam logic [CNT_W-1:0] FULL = '1;

  wdt_ratio_e ratio;
  logic       run;
  logic       active;
  logic       tick;

  wdt_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_sub_i  (src_sub_i),
    .ctrl_we_i  (ctrl_we_i),
    .ctrl_sel_i (ctrl_sel_i),
    .start_we_i (start_we_i),
    .ratio_o    (ratio),
    .run_o      (run)
  );

  assign active = run && !hold_i;

  wdt_prescaler #(
    .DIV_SUB  (DIV_SUB),
    .DIV_FAST (DIV_FAST),
    .DIV_SLOW (DIV_SLOW),
    .PRE_W    (PRE_W)
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run),
    .active_i (active),
    .ratio_i  (ratio),
    .tick_o   (tick)
  );

  wdt_down_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick),
    .load_i (start_we_i),
    .cnt_o  (count_o),
    .nmi_o  (nmi_req_o)
  );

  // R1
  idle_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (count_o == FULL && !nmi_req_o));

  // R5
  nmi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req_o |=> !nmi_req_o);

  // R8
  start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_we_i |=> !nmi_req_o);

  // R7
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !start_we_i) |=> ($stable(count_o) && !nmi_req_o));

endmodule

// File: tb/wdt_prescaled_bench.sv
module wdt_prescaled_bench;

  localparam int TW   = 6;
  localparam int NPER = 1 << TW;
  localparam int FULL = NPER - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          src_sub_i = 1'b0;
  logic          ctrl_we_i = 1'b0;
  logic          ctrl_sel_i = 1'b0;
  logic          start_we_i = 1'b0;
  logic          hold_i = 1'b0;
  logic          nmi_req_o;
  logic [TW-1:0] count_o;

  int  total = 0;
  int  fails = 0;
  bit  done = 1'b0;
  bit  model_on = 1'b0;

  always #10 clk = ~clk;

  wdt_prescaled #(.CNT_W(TW)) u_wdt_prescaled (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_sub_i  (src_sub_i),
    .ctrl_we_i  (ctrl_we_i),
    .ctrl_sel_i (ctrl_sel_i),
    .start_we_i (start_we_i),
    .hold_i     (hold_i),
    .nmi_req_o  (nmi_req_o),
    .count_o    (count_o)
  );

  function automatic int div_of(input bit sub, input bit sel);
    if (sub) return 2;
    return sel ? 128 : 16;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference state derived from the requirements
  bit m_run, m_sel, m_nmi;
  int m_pre, m_term, m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run <= 0; m_sel <= 0; m_nmi <= 0;
      m_pre <= 0; m_term <= 15; m_cnt <= FULL;
    end else begin
      bit act, tk;
      act = m_run && !hold_i;
      tk  = act && (m_pre == m_term);
      if (ctrl_we_i) m_sel <= ctrl_sel_i;
      if (start_we_i) m_run <= 1;
      if (!m_run) m_term <= div_of(src_sub_i, m_sel) - 1;
      else if (tk) begin m_pre <= 0; m_term <= div_of(src_sub_i, m_sel) - 1; end
      else if (act) m_pre <= m_pre + 1;
      m_nmi <= tk && (m_cnt == 0) && !start_we_i;
      if (start_we_i) m_cnt <= FULL;
      else if (tk) m_cnt <= (m_cnt == 0) ? FULL : m_cnt - 1;
    end
  end

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      chk(int'(count_o) == m_cnt, "R2/R6/R9 model count", int'(count_o), m_cnt);
      chk(nmi_req_o == m_nmi, "R5/R7/R8 model nmi", int'(nmi_req_o), int'(m_nmi));
    end
  end

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 0; src_sub_i = 0; ctrl_we_i = 0; ctrl_sel_i = 0;
    start_we_i = 0; hold_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic write_sel(input bit v);
    ctrl_we_i = 1; ctrl_sel_i = v;
    @(negedge clk);
    ctrl_we_i = 0;
  endtask

  // Start at a negedge and count edges until nmi. kind: 0 none, 1 refresh
  // at act_at, 2 select-field write of 1 at act_at, 3 hold from act_at for hlen.
  task automatic measure(input int kind, input int act_at, input int hlen,
                         output int k, output int c_at, output int c_after,
                         output int n_after, output int c_end);
    k = 0; c_at = -1; c_after = -1; n_after = -1; c_end = -1;
    start_we_i = 1;
    forever begin
      @(negedge clk);
      k++;
      start_we_i = 0; ctrl_we_i = 0;
      if (k == act_at + 1) begin c_after = int'(count_o); n_after = int'(nmi_req_o); end
      if (kind == 3 && k == act_at + hlen) begin hold_i = 0; c_end = int'(count_o); end
      if (k == act_at) begin
        c_at = int'(count_o);
        if (kind == 1) start_we_i = 1;
        if (kind == 2) begin ctrl_we_i = 1; ctrl_sel_i = 1; end
        if (kind == 3) hold_i = 1;
      end
      if (nmi_req_o || k > 20000) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int k, ca, caf, naf, ce;
    bit seen;

    // R1: reset state and idle
    reset_dut();
    chk(int'(count_o) == FULL, "R1 reset count", int'(count_o), FULL);
    chk(nmi_req_o == 0, "R1 reset nmi", int'(nmi_req_o), 0);
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (nmi_req_o || int'(count_o) != FULL) seen = 1;
    end
    chk(!seen, "R1 idle without start", int'(seen), 0);

    // R3 main oscillator, both ratios
    reset_dut();
    measure(0, -5, 0, k, ca, caf, naf, ce);
    chk(k == 16 * NPER + 1, "R3 ratio 16 period", k, 16 * NPER + 1);
    chk(int'(count_o) == FULL, "R5 wrap value", int'(count_o), FULL);
    @(negedge clk);
    chk(nmi_req_o == 0, "R5 single-cycle nmi", int'(nmi_req_o), 0);
    // second period, started by nothing: prescaler and counter keep going
    k = 1;
    while (!nmi_req_o && k < 20000) begin @(negedge clk); k++; end
    chk(k == 16 * NPER, "R5 free-running second period", k, 16 * NPER);

    reset_dut();
    write_sel(1);
    measure(0, -5, 0, k, ca, caf, naf, ce);
    chk(k == 128 * NPER + 1, "R3 ratio 128 period", k, 128 * NPER + 1);

    // R4 sub oscillator ignores the select field
    reset_dut();
    src_sub_i = 1;
    write_sel(1);
    measure(0, -5, 0, k, ca, caf, naf, ce);
    chk(k == 2 * NPER + 1, "R4 sub with select 1", k, 2 * NPER + 1);
    reset_dut();
    src_sub_i = 1;
    measure(0, -5, 0, k, ca, caf, naf, ce);
    chk(k == 2 * NPER + 1, "R4 sub with select 0", k, 2 * NPER + 1);

    // R6 refresh mid-period keeps prescaler phase; R2 reload value
    reset_dut();
    measure(1, 100, 0, k, ca, caf, naf, ce);
    chk(ca == FULL - 6, "R6 count before refresh", ca, FULL - 6);
    chk(caf == FULL, "R2 reload after refresh", caf, FULL);
    chk(k == 112 + 16 * FULL + 1, "R6 prescaler phase kept", k, 112 + 16 * FULL + 1);

    // R8 refresh on the underflow edge
    reset_dut();
    measure(1, 16 * NPER, 0, k, ca, caf, naf, ce);
    chk(naf == 0, "R8 no nmi on collision", naf, 0);
    chk(caf == FULL, "R8 reload on collision", caf, FULL);
    chk(k == 16 * NPER + 16 * NPER + 1, "R8 next period after collision", k, 32 * NPER + 1);

    // R7 hold freezes and resumes
    reset_dut();
    measure(3, 200, 37, k, ca, caf, naf, ce);
    chk(ca == FULL - 12, "R7 count at hold start", ca, FULL - 12);
    chk(ce == FULL - 12, "R7 count at hold end", ce, FULL - 12);
    chk(k == 16 * NPER + 1 + 37, "R7 period stretched by hold", k, 16 * NPER + 38);

    // R9 ratio change at next rollover
    reset_dut();
    measure(2, 3, 0, k, ca, caf, naf, ce);
    chk(k == 16 + 128 * FULL + 1, "R9 switch at rollover", k, 16 + 128 * FULL + 1);

    // R10 running survives hold; random traffic against the reference
    reset_dut();
    model_on = 1;
    for (int i = 0; i < 24000; i++) begin
      @(negedge clk);
      start_we_i = ($urandom_range(0, 399) == 0);
      ctrl_we_i  = ($urandom_range(0, 299) == 0);
      ctrl_sel_i = $urandom_range(0, 1);
      if ($urandom_range(0, 49) == 0) hold_i = ~hold_i;
      if ($urandom_range(0, 1499) == 0) src_sub_i = ~src_sub_i;
      if (i == 12000) begin
        model_on = 0;
        reset_dut();
        model_on = 1;
      end
    end
    model_on = 0;

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
  end

endmodule